// File: doc/BRIEF.md
# Crosspoint routing-map controller

This block keeps the routing map of a crosspoint with 36 data inputs and 37 outputs. The last output is an internal diagnostic channel. For every output it drives a 6-bit select code for that output's multiplexer, together with an enable bit. Each output takes exactly one input at a time. Any input may be picked by several outputs, so broadcast and multicast need no special handling.

A host writes one (input code, output address) pair per accepted transfer into a staging register set. The live map does not move until a commit strobe copies every staged entry into the active set in one cycle. Many assignments can therefore be queued and then applied to all outputs at the same instant. Writing the disable code turns an output off. An initialise input forces a straight-through map into both register sets. A combinational readback port returns the active code of any output address.

The write port uses valid/ready. A transfer is taken on a clock edge where `wr_valid`, `wr_ready` and `wr_cs` are all high. `wr_ready` drops only while `init` is high, and a host holding `wr_valid` simply waits. Commit, initialise and readback are plain control pins.

Top module: `xpt_map_ctrl`

## Requirements
- R1: While `rst_n` is low, and from the first edge after reset, output k selects input k for k in 0..35. Output 36 selects input 0, and every `en_o` bit is 1.
- R2: An accepted write stores `wr_in` in the staging entry of output `wr_out`. `sel_o` and `en_o` do not change until a commit.
- R3: When `wr_cs` is low, or `wr_valid` is low, the write is ignored. A following commit leaves the active map unchanged.
- R4: When `commit` is high at an edge, all 37 active entries take their staged values from before that edge. The new map is visible after that edge.
- R5: Code 63 is the disable code. After it is committed, the output's `sel_o` field reads 63 and its `en_o` bit is 0. Any code 0..35 sets `en_o` to 1.
- R6: A write whose `wr_in` is in 36..62 is ignored, and the staged entry keeps its earlier value.
- R7: A write whose `wr_out` is 37 or above is ignored, and no staged entry changes.
- R8: When a write and a commit meet at one edge, the active map takes the staging contents from before that write. The written value stays staged for the next commit.
- R9: While `init` is high, `wr_ready` is 0. At each such edge both register sets load the R1 map, and this takes priority over a write or a commit in the same cycle.
- R10: `rd_data` equals the active code of output `rd_addr` in the same cycle. It is 63 when `rd_addr` is 37 or above.
- R11: One input code may be committed to several outputs at once. Each of those outputs then selects it.
- R12: Output field k of `sel_o` occupies bits [6k+5:6k]. Bit k of `en_o` belongs to output k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, loads the straight-through map |
| init | input | 1 | Identity preset for staging and active sets |
| wr_valid | input | 1 | Host write transfer offered |
| wr_ready | output | 1 | Write port can accept (low during init) |
| wr_cs | input | 1 | Chip select qualifying a write |
| wr_in | input | 6 | Input code, 0..35 or 63 for disable |
| wr_out | input | 6 | Output address, 0..36 |
| commit | input | 1 | Copy all staged entries into the active set |
| rd_addr | input | 6 | Readback output address |
| rd_data | output | 6 | Active code of the addressed output |
| sel_o | output | 222 | Active select codes, 6 bits per output |
| en_o | output | 37 | Per-output enable, 0 when disabled |

## Verification
A write and a commit can land on the same clock edge, and that race decides whether a fresh assignment leaks into the live map early. The bench drives both strobes together, with the written output chosen so that its staged and active values differ. It expects the active map to show the older staged value, and the new value to appear only after a later lone commit. Initialise is also raised together with a write and a commit, and the result must be the plain identity map. A behavioural model compares every output field, `wr_ready` and readback on every cycle.

// File: rtl/xpt_map_pkg.sv
package xpt_map_pkg;
  localparam int SEL_W = 6;
  typedef logic [SEL_W-1:0] sel_t;
  localparam sel_t OFF_CODE = '1;
endpackage

// File: rtl/xpt_wr_decode.sv
module xpt_wr_decode
  import xpt_map_pkg::*;
#(
  parameter int N_IN  = 36,
  parameter int N_OUT = 37
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  sel_t             code_in,
  input  sel_t             addr_in,
  output logic [N_OUT-1:0] load_vec
);
  localparam sel_t IN_LIM  = sel_t'(N_IN);
  localparam sel_t OUT_LIM = sel_t'(N_OUT);

  logic code_ok;
  logic addr_ok;

  assign code_ok = (code_in < IN_LIM) || (code_in == OFF_CODE);
  assign addr_ok = addr_in < OUT_LIM;

  for (genvar k = 0; k < N_OUT; k++) begin : g_dec
    assign load_vec[k] = fire && code_ok && addr_ok && (addr_in == sel_t'(k));
  end

  // R2
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_vec));

  // R6
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_in >= IN_LIM && code_in != OFF_CODE) |-> (load_vec == '0));

  // R7
  bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_in >= OUT_LIM) |-> (load_vec == '0));
endmodule

// File: rtl/xpt_chan_reg.sv
module xpt_chan_reg
  import xpt_map_pkg::*;
#(
  parameter sel_t ID_CODE = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic commit,
  input  logic load,
  input  sel_t load_val,
  output sel_t act_o
);
  sel_t stg;
  sel_t act;

  always_ff @(posedge clk) begin
    if (!rst_n || init) begin
      stg <= ID_CODE;
      act <= ID_CODE;
    end else begin
      if (commit) act <= stg;
      if (load)   stg <= load_val;
    end
  end

  assign act_o = act;

  // R4
  commit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !init) |=> (act == $past(stg)));

  // R2
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !init) |=> $stable(act));

  // R9
  init_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (act == ID_CODE && stg == ID_CODE));
endmodule

// File: rtl/xpt_read_mux.sv
module xpt_read_mux
  import xpt_map_pkg::*;
#(
  parameter int N_OUT = 37
) (
  input  sel_t act_arr [N_OUT],
  input  sel_t rd_addr,
  output sel_t rd_data
);
  localparam sel_t OUT_LIM = sel_t'(N_OUT);

  always_comb begin
    rd_data = OFF_CODE;
    for (int k = 0; k < N_OUT; k++) begin
      if (rd_addr < OUT_LIM && rd_addr == sel_t'(k)) rd_data = act_arr[k];
    end
  end
endmodule

// File: rtl/xpt_map_ctrl.sv
module xpt_map_ctrl
  import xpt_map_pkg::*;
#(
  parameter int N_IN  = 36,
  parameter int N_OUT = 37
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   init,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  input  logic                   wr_cs,
  input  logic [SEL_W-1:0]       wr_in,
  input  logic [SEL_W-1:0]       wr_out,
  input  logic                   commit,
  input  logic [SEL_W-1:0]       rd_addr,
  output logic [SEL_W-1:0]       rd_data,
  output logic [N_OUT*SEL_W-1:0] sel_o,
  output logic [N_OUT-1:0]       en_o
);
  localparam sel_t OUT_LIM = sel_t'(N_OUT);

  logic             wr_fire;
  logic [N_OUT-1:0] load_vec;
  sel_t             act_arr [N_OUT];

  assign wr_ready = !init;
  assign wr_fire  = wr_valid && wr_ready && wr_cs;

  xpt_wr_decode #(.N_IN(N_IN), .N_OUT(N_OUT)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (wr_fire),
    .code_in  (wr_in),
    .addr_in  (wr_out),
    .load_vec (load_vec)
  );

  for (genvar k = 0; k < N_OUT; k++) begin : g_chan
    localparam sel_t ID_CODE = (k < N_IN) ? sel_t'(k) : '0;
    xpt_chan_reg #(.ID_CODE(ID_CODE)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .init     (init),
      .commit   (commit),
      .load     (load_vec[k]),
      .load_val (wr_in),
      .act_o    (act_arr[k])
    );
    assign sel_o[k*SEL_W +: SEL_W] = act_arr[k];
    assign en_o[k] = (act_arr[k] != OFF_CODE);
  end

  xpt_read_mux #(.N_OUT(N_OUT)) u_rd (
    .act_arr (act_arr),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  // R10
  readback_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr < OUT_LIM) |-> (rd_data == act_arr[rd_addr]));

  // R9
  init_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (en_o == '1));
endmodule

// File: tb/xpt_map_ctrl_bench.sv
module xpt_map_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int NI = 36;
  localparam int NO = 37;

  logic clk = 0;
  logic rst_n = 0;
  logic init = 0;
  logic wr_valid = 0;
  logic wr_ready;
  logic wr_cs = 0;
  logic [5:0] wr_in = 0;
  logic [5:0] wr_out = 0;
  logic commit = 0;
  logic [5:0] rd_addr = 0;
  logic [5:0] rd_data;
  logic [NO*6-1:0] sel_o;
  logic [NO-1:0] en_o;

  int stg_m [NO];
  int act_m [NO];
  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";

  always #(CLK_P/2) clk = ~clk;

  xpt_map_ctrl u_xpt_map_ctrl (
    .clk(clk), .rst_n(rst_n), .init(init), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_cs(wr_cs), .wr_in(wr_in), .wr_out(wr_out),
    .commit(commit), .rd_addr(rd_addr), .rd_data(rd_data),
    .sel_o(sel_o), .en_o(en_o)
  );

  // behavioural reference, updated on each edge
  always @(posedge clk) begin
    if (!rst_n || init) begin
      for (int k = 0; k < NO; k++) begin
        stg_m[k] = (k < NI) ? k : 0;
        act_m[k] = stg_m[k];
      end
    end else begin
      if (commit)
        for (int k = 0; k < NO; k++) act_m[k] = stg_m[k];
      if (wr_valid && wr_cs && (int'(wr_out) < NO) &&
          (int'(wr_in) < NI || wr_in == 6'd63))
        stg_m[wr_out] = int'(wr_in);
    end
  end

  task automatic chk(input int act, input int exp, input string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  always begin
    @(posedge clk);
    #(CLK_P/4);
    for (int k = 0; k < NO; k++) begin
      chk(int'(sel_o[k*6 +: 6]), act_m[k], $sformatf("R12 sel[%0d]", k));
      chk(int'(en_o[k]), (act_m[k] != 63) ? 1 : 0, $sformatf("R5 en[%0d]", k));
    end
    chk(int'(wr_ready), init ? 0 : 1, "R9 wr_ready");
    chk(int'(rd_data), (int'(rd_addr) < NO) ? act_m[rd_addr] : 63, "R10 rd_data");
  end

  task automatic cyc(input bit v, input bit cs, input int i, input int o,
                     input bit cm, input bit in_i);
    @(negedge clk);
    wr_valid = v; wr_cs = cs; wr_in = 6'(i); wr_out = 6'(o);
    commit = cm; init = in_i;
    rd_addr = rd_addr + 6'd7;
  endtask

  task automatic idle(input int n);
    for (int j = 0; j < n; j++) cyc(0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 20000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    // R1 reset map, output 36 on input 0
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(3);
    // R2 staged writes do not reach the active map
    cur_req = "R2";
    cyc(1, 1, 10, 5, 0, 0);
    cyc(1, 1, 35, 0, 0, 0);
    idle(3);
    // R4 commit applies both at once
    cur_req = "R4";
    cyc(0, 0, 0, 0, 1, 0);
    idle(2);
    // R11 multicast of input 7
    cur_req = "R11";
    cyc(1, 1, 7, 1, 0, 0);
    cyc(1, 1, 7, 2, 0, 0);
    cyc(1, 1, 7, 36, 0, 0);
    cyc(0, 0, 0, 0, 1, 0);
    idle(2);
    // R3 chip select low or valid low
    cur_req = "R3";
    cyc(1, 0, 9, 3, 0, 0);
    cyc(0, 1, 9, 3, 0, 0);
    cyc(0, 0, 0, 0, 1, 0);
    idle(2);
    // R5 disable code
    cur_req = "R5";
    cyc(1, 1, 63, 4, 0, 0);
    cyc(0, 0, 0, 0, 1, 0);
    idle(2);
    cyc(1, 1, 20, 4, 1, 0);
    cyc(0, 0, 0, 0, 1, 0);
    idle(2);
    // R6 illegal codes 36 and 62
    cur_req = "R6";
    cyc(1, 1, 36, 6, 0, 0);
    cyc(1, 1, 62, 6, 0, 0);
    cyc(0, 0, 0, 0, 1, 0);
    idle(2);
    // R7 addresses past the last output
    cur_req = "R7";
    cyc(1, 1, 1, 37, 0, 0);
    cyc(1, 1, 1, 63, 0, 0);
    cyc(0, 0, 0, 0, 1, 0);
    idle(2);
    // R8 write and commit on the same edge
    cur_req = "R8";
    cyc(1, 1, 22, 8, 1, 0);
    idle(2);
    cyc(0, 0, 0, 0, 1, 0);
    idle(2);
    // R9 init beats a write and a commit
    cur_req = "R9";
    cyc(1, 1, 63, 9, 0, 0);
    cyc(1, 1, 30, 10, 1, 1);
    cyc(1, 1, 31, 11, 0, 1);
    idle(2);
    cyc(0, 0, 0, 0, 1, 0);
    idle(2);
    // R10 readback sweep over a mixed map
    cur_req = "R10";
    for (int k = 0; k < NO; k += 3) cyc(1, 1, (k * 5) % NI, k, 0, 0);
    cyc(1, 1, 63, 12, 1, 0);
    idle(64);
    finish_run();
  end
endmodule